// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a synthesizable model of a 4 Kbit serial EEPROM that sits on a three-wire bus: a chip select, a serial clock and a serial data input, plus a data output with its own drive enable so the pad can float. All inputs are oversampled in the system clock domain. The serial clock must therefore hold each level for at least two system clocks. The block decodes a start bit, a two-bit opcode and an address. It then reads one location, programs one location, erases one location, erases or fills the whole array, or sets and clears the write-enable latch.

An organization input selects one of two views of the same storage: 256 sixteen-bit words or 512 bytes. The address length, the data length and the total clock count of each instruction follow from that choice. Programming is self-timed. A counter holds the block busy for a number of system clock cycles set by parameters, and the data output reports ready or busy while the host keeps the device selected.

Top module: `serial_prom`

## Requirements
- R1: Rising serial-clock edges that sample 0 while the block is idle are ignored. An instruction begins with the first 1 sampled. The two bits that follow are the opcode, MSB first: 10 reads, 01 writes, 11 erases one location, 00 selects an extended command.
- R2: For opcode 00, the two most significant address bits choose the extended command: 11 sets the write-enable latch, 00 clears it, 10 erases every location, 01 fills every location with the data that follows. The other address bits have no effect.
- R3: With org_word=1 the address is 8 bits and data is 16 bits. With org_word=0 the address is 9 bits and data is 8 bits. Addresses and data are sent MSB first. Byte address b is bits [15:8] of word b[8:1] when b[0]=0, and bits [7:0] of that word when b[0]=1.
- R4: A read drives 0 after the edge that samples the last address bit. It then drives one data bit, MSB first, after each of the following edges. A word read therefore spans 27 edges and a byte read spans 20.
- R5: A write replaces the addressed location with the shifted data. An erase sets it to all ones. Erase-all sets every word to all ones. Fill sets every word to the data, with the byte repeated in both halves in byte mode.
- R6: The write-enable latch is clear after reset. Write, erase, erase-all and fill change nothing while it is clear.
- R7: After the edge that completes a write, erase, erase-all or fill, ser_dout_en is 1. From the next system clock, ser_dout is 0 for T_WR_BYTE cycles (single location, byte mode), T_WR_WORD cycles (single location, word mode) or T_BULK cycles (erase-all, fill), and then 1. If the latch was clear, ser_dout is 1 at once. When chip_sel is raised again during busy, the status is shown again.
- R8: ser_dout_en is 0 while chip_sel is low, while a header is being shifted in, and after either latch command.
- R9: Lowering chip_sel before an instruction's last bit abandons it and changes neither storage nor the latch.
- R10: While programming is in progress, start bits are ignored, so no instruction is accepted.
- R11: Extra serial-clock edges after an instruction completes have no effect until chip_sel goes low. After a read, the last data bit stays on ser_dout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all serial inputs are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| org_word | input | 1 | 1 selects 16-bit word organization, 0 selects 8-bit byte organization |
| chip_sel | input | 1 | Active-high device select |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_din | input | 1 | Serial instruction, address and data input |
| ser_dout | output | 1 | Serial data output: read data or ready/busy status |
| ser_dout_en | output | 1 | Drive enable for ser_dout; 0 means high impedance |

## Verification
The embedded properties check several rules on every cycle. No store commit may occur while the programming counter is running. Every commit needs the write-enable latch. The output stays disabled during header shifting. The first bit of a read is the dummy zero. A commit must start a busy period that counts down one step per cycle. The bench scenarios cover what only an end-to-end sequence can show: the two address mappings onto one array, that aborted and locked operations leave storage intact, the exact busy durations measured at the pin, and that a command issued during busy is really dropped, shown by the instructions that follow it.

// File: rtl/sprom_pkg.sv
package sprom_pkg;

  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    EX_LOCK   = 2'b00,
    EX_FILL   = 2'b01,
    EX_CLEAR  = 2'b10,
    EX_UNLOCK = 2'b11
  } ext_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_DATA,
    ST_READ,
    ST_HOLD
  } st_e;

endpackage

// File: rtl/sprom_store.sv
module sprom_store #(
  parameter int WORD_W = 16,
  parameter int WORDS  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_all,
  input  logic [$clog2(WORDS)-1:0] wr_idx,
  input  logic [WORD_W-1:0] wr_mask,
  input  logic [WORD_W-1:0] wr_val,
  input  logic [$clog2(WORDS)-1:0] rd_idx,
  output logic [WORD_W-1:0] rd_word
);
  localparam int AW = $clog2(WORDS);

  logic [WORD_W-1:0] mem [WORDS];
  logic [WORDS-1:0]  hit;

  // per-entry write select
  for (genvar g = 0; g < WORDS; g++) begin : g_sel
    assign hit[g] = wr_en & (wr_all | (wr_idx == AW'(g)));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < WORDS; i++) begin
      if (hit[i]) mem[i] <= (mem[i] & ~wr_mask) | (wr_val & wr_mask);
    end
  end

  assign rd_word = mem[rd_idx];

  // R5: a full-array erase leaves the first and last words all ones
  assert_bulk_erase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_all && (&wr_val) && (&wr_mask)) |=> ((&mem[0]) && (&mem[WORDS-1])));

endmodule

// File: rtl/sprom_prog_timer.sv
module sprom_prog_timer #(
  parameter int T_WR_BYTE = 40,
  parameter int T_WR_WORD = 80,
  parameter int T_BULK    = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic bulk,
  input  logic word_mode,
  output logic busy
);
  localparam int TMAX = (T_BULK > T_WR_WORD) ?
                        ((T_BULK > T_WR_BYTE) ? T_BULK : T_WR_BYTE) :
                        ((T_WR_WORD > T_WR_BYTE) ? T_WR_WORD : T_WR_BYTE);
  localparam int CW = $clog2(TMAX + 1);

  logic [CW-1:0] cnt_q, cnt_d, dur;

  always_comb begin
    if (bulk)           dur = CW'(T_BULK);
    else if (word_mode) dur = CW'(T_WR_WORD);
    else                dur = CW'(T_WR_BYTE);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (go)                 cnt_d = dur;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  // R7: a commit opens a busy window
  assert_go_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy);
  // R7: busy drops only after the final count
  assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(cnt_q) == CW'(1)));

endmodule

// File: rtl/sprom_cmd_fsm.sv
module sprom_cmd_fsm
  import sprom_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int AWW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_mode,
  input  logic              sel,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              busy,
  output logic [AWW-1:0]    rd_idx,
  input  logic [WORD_W-1:0] rd_word,
  output logic              pg_go,
  output logic              pg_all,
  output logic [AWW-1:0]    pg_idx,
  output logic [WORD_W-1:0] pg_mask,
  output logic [WORD_W-1:0] pg_val,
  output logic              sdo,
  output logic              sdo_en
);
  localparam int BYTE_W = WORD_W / 2;
  localparam int AWB    = AWW + 1;
  localparam int HW     = AWB + 2;
  localparam int MAXC   = (HW > WORD_W) ? HW : WORD_W;
  localparam int CW     = $clog2(MAXC + 1);
  localparam logic [CW-1:0] HEND_W = CW'(AWW + 1);
  localparam logic [CW-1:0] HEND_B = CW'(AWB + 1);
  localparam logic [CW-1:0] DLEN_W = CW'(WORD_W);
  localparam logic [CW-1:0] DLEN_B = CW'(BYTE_W);

  st_e               st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [HW-2:0]     hdr_q, hdr_d;
  logic [WORD_W-2:0] dat_q, dat_d;
  logic [WORD_W-1:0] rsh_q, rsh_d;
  logic [AWB-1:0]    addr_q, addr_d;
  logic              all_q, all_d, wen_q, wen_d, stat_q, stat_d;
  logic              rbit_q, rbit_d, sclk_q;

  logic              rise, hdr_end;
  logic [HW-1:0]     hdr_in;
  logic [WORD_W-1:0] dat_in, rd_pick, c_data;
  logic [1:0]        op_w, ex_w;
  logic [AWB-1:0]    ad_w, c_addr;
  logic [CW-1:0]     dlen;
  logic              commit, c_all, c_erase;

  // serial clock edge detection in the system clock domain
  assign rise    = sel & sclk & ~sclk_q;
  assign hdr_in  = {hdr_q, sdi};
  assign dat_in  = {dat_q, sdi};
  assign hdr_end = (cnt_q == (word_mode ? HEND_W : HEND_B));
  assign dlen    = word_mode ? DLEN_W : DLEN_B;
  assign op_w    = word_mode ? hdr_in[AWW+1:AWW] : hdr_in[AWB+1:AWB];
  assign ex_w    = word_mode ? hdr_in[AWW-1:AWW-2] : hdr_in[AWB-1:AWB-2];
  assign ad_w    = word_mode ? {1'b0, hdr_in[AWW-1:0]} : hdr_in[AWB-1:0];
  assign rd_idx  = word_mode ? ad_w[AWW-1:0] : ad_w[AWB-1:1];

  always_comb begin
    if (word_mode)      rd_pick = rd_word;
    else if (ad_w[0])   rd_pick = {rd_word[BYTE_W-1:0], {BYTE_W{1'b0}}};
    else                rd_pick = {rd_word[WORD_W-1:BYTE_W], {BYTE_W{1'b0}}};
  end

  // next-state logic
  always_comb begin
    st_d = st_q;     cnt_d = cnt_q;   hdr_d = hdr_q;   dat_d = dat_q;
    rsh_d = rsh_q;   addr_d = addr_q; all_d = all_q;   wen_d = wen_q;
    stat_d = stat_q; rbit_d = rbit_q;
    commit = 1'b0;   c_all = 1'b0;    c_erase = 1'b0;
    c_addr = addr_q; c_data = dat_in;
    if (!sel) begin
      st_d   = ST_IDLE;
      stat_d = 1'b0;
      cnt_d  = '0;
    end else if (rise) begin
      case (st_q)
        ST_IDLE: begin
          if (sdi && !busy) begin
            st_d  = ST_HDR;
            cnt_d = '0;
            hdr_d = '0;
          end
        end
        ST_HDR: begin
          hdr_d = hdr_in[HW-2:0];
          cnt_d = cnt_q + 1'b1;
          if (hdr_end) begin
            cnt_d  = '0;
            addr_d = ad_w;
            case (op_e'(op_w))
              OP_READ: begin
                st_d   = ST_READ;
                rsh_d  = rd_pick;
                rbit_d = 1'b0;
              end
              OP_WRITE: begin
                st_d  = ST_DATA;
                all_d = 1'b0;
              end
              OP_ERASE: begin
                st_d    = ST_HOLD;
                stat_d  = 1'b1;
                commit  = wen_q;
                c_erase = 1'b1;
                c_addr  = ad_w;
              end
              default: begin
                st_d = ST_HOLD;
                case (ext_e'(ex_w))
                  EX_UNLOCK: wen_d = 1'b1;
                  EX_LOCK:   wen_d = 1'b0;
                  EX_CLEAR: begin
                    stat_d  = 1'b1;
                    commit  = wen_q;
                    c_all   = 1'b1;
                    c_erase = 1'b1;
                  end
                  default: begin
                    st_d  = ST_DATA;
                    all_d = 1'b1;
                  end
                endcase
              end
            endcase
          end
        end
        ST_DATA: begin
          dat_d = dat_in[WORD_W-2:0];
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == dlen - 1'b1) begin
            st_d   = ST_HOLD;
            stat_d = 1'b1;
            commit = wen_q;
            c_all  = all_q;
          end
        end
        ST_READ: begin
          if (cnt_q != dlen) begin
            rbit_d = rsh_q[WORD_W-1];
            rsh_d  = {rsh_q[WORD_W-2:0], 1'b0};
            cnt_d  = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
      all_q  <= 1'b0;
      wen_q  <= 1'b0;
      stat_q <= 1'b0;
      rbit_q <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
      all_q  <= all_d;
      wen_q  <= wen_d;
      stat_q <= stat_d;
      rbit_q <= rbit_d;
      sclk_q <= sclk;
    end
  end

  // datapath shift registers, no reset needed
  always_ff @(posedge clk) begin
    hdr_q <= hdr_d;
    dat_q <= dat_d;
    rsh_q <= rsh_d;
  end

  // program request toward store and timer
  assign pg_go  = commit;
  assign pg_all = c_all;
  assign pg_idx = word_mode ? c_addr[AWW-1:0] : c_addr[AWB-1:1];
  always_comb begin
    if (c_all || word_mode) pg_mask = '1;
    else if (c_addr[0])     pg_mask = {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};
    else                    pg_mask = {{BYTE_W{1'b1}}, {BYTE_W{1'b0}}};
    if (c_erase)            pg_val = '1;
    else if (word_mode)     pg_val = c_data;
    else                    pg_val = {c_data[BYTE_W-1:0], c_data[BYTE_W-1:0]};
  end

  assign sdo_en = sel & ((st_q == ST_READ) | stat_q | busy);
  assign sdo    = (st_q == ST_READ) ? rbit_q : ~busy;

  // R6: storage is only touched with the latch set
  assert_latch_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pg_go |-> wen_q);
  // R8: no drive while a header is arriving
  assert_hdr_hiz_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HDR) |-> !sdo_en);
  // R4: the first bit of a read is the dummy zero
  assert_dummy_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_READ) && ($past(st_q) != ST_READ)) |-> !sdo);
  // R10: no decoding is in progress during a busy window
  assert_busy_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((st_q == ST_IDLE) || (st_q == ST_HOLD)));

endmodule

// File: rtl/serial_prom.sv
module serial_prom #(
  parameter int WORD_W    = 16,
  parameter int MEM_BITS  = 4096,
  parameter int T_WR_BYTE = 40,
  parameter int T_WR_WORD = 80,
  parameter int T_BULK    = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic org_word,
  input  logic chip_sel,
  input  logic ser_clk,
  input  logic ser_din,
  output logic ser_dout,
  output logic ser_dout_en
);
  localparam int WORDS = MEM_BITS / WORD_W;
  localparam int AWW   = $clog2(WORDS);

  logic [1:0]        rst_pipe;
  logic              rst_s;
  logic              busy, pg_go, pg_all;
  logic [AWW-1:0]    rd_idx, pg_idx;
  logic [WORD_W-1:0] rd_word, pg_mask, pg_val;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  sprom_cmd_fsm #(.WORD_W(WORD_W), .AWW(AWW)) u_fsm (
    .clk(clk), .rst_n(rst_s), .word_mode(org_word), .sel(chip_sel),
    .sclk(ser_clk), .sdi(ser_din), .busy(busy), .rd_idx(rd_idx),
    .rd_word(rd_word), .pg_go(pg_go), .pg_all(pg_all), .pg_idx(pg_idx),
    .pg_mask(pg_mask), .pg_val(pg_val), .sdo(ser_dout), .sdo_en(ser_dout_en)
  );

  sprom_prog_timer #(.T_WR_BYTE(T_WR_BYTE), .T_WR_WORD(T_WR_WORD), .T_BULK(T_BULK)) u_timer (
    .clk(clk), .rst_n(rst_s), .go(pg_go), .bulk(pg_all),
    .word_mode(org_word), .busy(busy)
  );

  sprom_store #(.WORD_W(WORD_W), .WORDS(WORDS)) u_store (
    .clk(clk), .rst_n(rst_s), .wr_en(pg_go), .wr_all(pg_all), .wr_idx(pg_idx),
    .wr_mask(pg_mask), .wr_val(pg_val), .rd_idx(rd_idx), .rd_word(rd_word)
  );

  // R10: the decoder never commits while the timer runs
  assert_no_commit_busy_R10: assert property (@(posedge clk) disable iff (!rst_s)
    busy |-> !pg_go);
  // R8: output floats whenever the device is deselected
  assert_desel_hiz_R8: assert property (@(posedge clk) disable iff (!rst_s)
    !chip_sel |-> !ser_dout_en);

endmodule

// File: tb/serial_prom_bench.sv
`timescale 1ns/1ps
module serial_prom_bench;
  localparam int TB = 30, TW = 50, TA = 120;

  logic clk = 1'b0, rst_n = 1'b0, org_word = 1'b1;
  logic chip_sel = 1'b0, ser_clk = 1'b0, ser_din = 1'b0;
  logic ser_dout, ser_dout_en;
  int errs = 0, checks = 0;
  logic [15:0] mdl [256];
  bit wen_m = 1'b0;

  serial_prom #(.T_WR_BYTE(TB), .T_WR_WORD(TW), .T_BULK(TA)) u_serial_prom (
    .clk(clk), .rst_n(rst_n), .org_word(org_word), .chip_sel(chip_sel),
    .ser_clk(ser_clk), .ser_din(ser_din), .ser_dout(ser_dout), .ser_dout_en(ser_dout_en)
  );

  always #2.5 clk = ~clk;

  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int hlen(bit wm); return wm ? 11 : 12; endfunction
  function automatic int dlen(bit wm); return wm ? 16 : 8; endfunction
  function automatic logic [31:0] hdr(bit wm, logic [1:0] op, logic [8:0] a);
    return wm ? {21'b0, 1'b1, op, a[7:0]} : {20'b0, 1'b1, op, a[8:0]};
  endfunction
  function automatic logic [15:0] exp_rd(bit wm, logic [8:0] a);
    if (wm) return mdl[a[7:0]];
    return a[0] ? {8'h0, mdl[a[8:1]][7:0]} : {8'h0, mdl[a[8:1]][15:8]};
  endfunction
  function automatic int pdur(bit wm); return wen_m ? (wm ? TW : TB) : 0; endfunction

  task automatic mdl_put(bit wm, logic [8:0] a, logic [15:0] d);
    if (!wen_m) return;
    if (wm) mdl[a[7:0]] = d;
    else if (a[0]) mdl[a[8:1]][7:0] = d[7:0];
    else mdl[a[8:1]][15:8] = d[7:0];
  endtask

  task automatic tick_bit(input logic b, output logic o, output logic oe);
    ser_din = b; ser_clk = 1'b1;
    repeat (2) @(negedge clk);
    o = ser_dout; oe = ser_dout_en;
    ser_clk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic deselect();
    chip_sel = 1'b0; ser_clk = 1'b0; ser_din = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // exp_dur: -1 no status poll, >=0 poll busy after the last bit
  task automatic run(input logic [31:0] v, input int n, input int lead, input int exp_dur,
                     input string tag, output logic [31:0] rx, output logic [31:0] rxe);
    logic o, oe;
    rx = '0; rxe = '0;
    chip_sel = 1'b1; @(negedge clk);
    for (int i = 0; i < lead; i++) tick_bit(1'b0, o, oe);
    for (int i = 0; i < n; i++) begin
      if (i == n - 1 && exp_dur >= 0) begin
        int cnt = 0;
        bit done = 1'b0;
        ser_din = v[0]; ser_clk = 1'b1;
        for (int k = 0; k < 2000 && !done; k++) begin
          @(negedge clk);
          if (ser_dout_en && !ser_dout) cnt++;
          else done = 1'b1;
        end
        chk(ser_dout_en && ser_dout && cnt == exp_dur, tag, cnt, exp_dur);
        ser_clk = 1'b0;
        repeat (2) @(negedge clk);
      end else begin
        tick_bit(v[n-1-i], o, oe);
        rx[i] = o; rxe[i] = oe;
      end
    end
  endtask

  task automatic do_read(bit wm, logic [8:0] a, int lead, int extra);
    logic [31:0] rx, rxe;
    logic [15:0] got, ex;
    logic o, oe;
    int hl = hlen(wm), dw = dlen(wm);
    org_word = wm;
    ex = exp_rd(wm, a);
    run(hdr(wm, 2'b10, a) << dw, hl + dw, lead, -1, "R4", rx, rxe);
    got = '0;
    for (int j = 0; j < dw; j++) got = {got[14:0], rx[hl+j]};
    chk(rxe[hl-1] && !rx[hl-1], "R4 dummy zero", {rxe[hl-1], rx[hl-1]}, 32'h2);
    chk(got == ex, wm ? "R4 R3 word read" : "R4 R3 byte read", got, ex);
    chk((rxe & ((32'h1 << (hl - 1)) - 1)) == 0, "R8 header hi-z", rxe, 0);
    for (int e = 0; e < extra; e++) begin
      tick_bit(~ex[0], o, oe);
      chk(oe && o == ex[0], "R11 read tail hold", {oe, o}, {1'b1, ex[0]});
    end
    deselect();
  endtask

  task automatic do_write(bit wm, logic [8:0] a, logic [15:0] d, string tag);
    logic [31:0] rx, rxe;
    int dw = dlen(wm);
    org_word = wm;
    run((hdr(wm, 2'b01, a) << dw) | 32'(d & ((17'h1 << dw) - 1)), hlen(wm) + dw, 0, pdur(wm), tag, rx, rxe);
    mdl_put(wm, a, d);
    deselect();
  endtask

  task automatic do_erase(bit wm, logic [8:0] a);
    logic [31:0] rx, rxe;
    org_word = wm;
    run(hdr(wm, 2'b11, a), hlen(wm), 0, pdur(wm), "R7 R5 erase", rx, rxe);
    mdl_put(wm, a, 16'hFFFF);
    deselect();
  endtask

  task automatic do_ext(bit wm, logic [1:0] code, logic [15:0] d);
    logic [31:0] rx, rxe;
    logic [8:0] a;
    int hl = hlen(wm), dw = dlen(wm);
    org_word = wm;
    a = 9'($urandom);
    if (wm) a[7:6] = code; else a[8:7] = code;
    if (code == 2'b11 || code == 2'b00) begin
      run(hdr(wm, 2'b00, a), hl, 0, -1, "R2", rx, rxe);
      chk(rxe[hl-1] == 1'b0, "R8 R2 latch cmd hi-z", rxe[hl-1], 0);
      wen_m = code[0];
    end else if (code == 2'b10) begin
      run(hdr(wm, 2'b00, a), hl, 0, wen_m ? TA : 0, "R7 R2 erase-all busy", rx, rxe);
      if (wen_m) for (int i = 0; i < 256; i++) mdl[i] = 16'hFFFF;
    end else begin
      run((hdr(wm, 2'b00, a) << dw) | 32'(d & ((17'h1 << dw) - 1)), hl + dw, 0,
          wen_m ? TA : 0, "R7 R2 fill busy", rx, rxe);
      if (wen_m) for (int i = 0; i < 256; i++) mdl[i] = wm ? d : {d[7:0], d[7:0]};
    end
    deselect();
  endtask

  initial begin
    logic [31:0] rx, rxe;
    logic o, oe;
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ser_dout_en == 1'b0, "R8 reset deselected", ser_dout_en, 0);
    chip_sel = 1'b1; repeat (2) @(negedge clk);
    chk(ser_dout_en == 1'b0, "R8 reset selected idle", ser_dout_en, 0);
    chip_sel = 1'b0; repeat (2) @(negedge clk);

    // R6: latch clear after reset, programming shows ready at once
    do_write(1'b1, 9'h05, 16'h1234, "R6 locked write ready");
    do_ext(1'b1, 2'b10, 16'h0);
    do_ext(1'b1, 2'b11, 16'h0);
    do_ext(1'b1, 2'b10, 16'h0);
    do_read(1'b1, 9'h05, 0, 0);
    do_read(1'b0, 9'h1FF, 0, 0);
    do_ext(1'b0, 2'b00, 16'h0);
    do_write(1'b1, 9'h05, 16'h1234, "R6 locked write");
    do_erase(1'b0, 9'h0A);
    do_read(1'b1, 9'h05, 0, 0);
    do_read(1'b1, 9'h05, 0, 0);

    // R3 mapping and R1 leading zeros
    do_ext(1'b0, 2'b11, 16'h0);
    do_write(1'b1, 9'h12, 16'hABCD, "R7 R5 word write busy");
    do_read(1'b0, 9'h024, 3, 0);
    do_read(1'b0, 9'h025, 1, 0);
    do_write(1'b0, 9'h025, 16'h0077, "R7 R5 byte write busy");
    do_read(1'b1, 9'h12, 2, 2);
    do_erase(1'b0, 9'h024);
    do_read(1'b1, 9'h12, 0, 0);

    // R9: abort in data phase and in header phase
    org_word = 1'b1;
    run(hdr(1'b1, 2'b01, 9'h12) << 5 | 32'h15, 16, 0, -1, "R9", rx, rxe);
    deselect();
    org_word = 1'b0;
    run(32'b1001, 4, 0, -1, "R9", rx, rxe);
    deselect();
    do_read(1'b1, 9'h12, 0, 0);
    chk(exp_rd(1'b1, 9'h12) == 16'hFF77, "R9 model sanity", exp_rd(1'b1, 9'h12), 16'hFF77);

    // R11: clocks after a finished write change nothing
    org_word = 1'b1;
    run((hdr(1'b1, 2'b01, 9'h30) << 16) | 32'h5A5A, 27, 0, TW, "R7 write busy", rx, rxe);
    mdl[8'h30] = 16'h5A5A;
    for (int i = 0; i < 12; i++) tick_bit(i[0] | (i < 3), o, oe);
    deselect();
    do_read(1'b1, 9'h30, 0, 0);

    // R10/R7: instruction during busy dropped, status on reselect
    org_word = 1'b1;
    run((hdr(1'b1, 2'b01, 9'h40) << 16) | 32'h0F0F, 27, 0, -1, "R10", rx, rxe);
    mdl[8'h40] = 16'h0F0F;
    deselect();
    chip_sel = 1'b1; repeat (2) @(negedge clk);
    chk(ser_dout_en && !ser_dout, "R7 status on reselect", {ser_dout_en, ser_dout}, 32'h2);
    for (int i = 0; i < 11; i++) tick_bit(hdr(1'b1, 2'b00, 9'h00)[10-i], o, oe);
    deselect();
    repeat (TW + 5) @(negedge clk);
    do_write(1'b1, 9'h41, 16'hC3C3, "R10 latch kept after busy");
    do_read(1'b1, 9'h41, 0, 0);
    do_read(1'b1, 9'h40, 0, 0);

    // R5 fill in byte mode
    do_ext(1'b0, 2'b01, 16'h003C);
    do_read(1'b1, 9'h07, 0, 0);
    do_read(1'b0, 9'h1FE, 0, 0);

    // constrained random mix
    for (int it = 0; it < 220; it++) begin
      int r = $urandom % 100;
      bit wm = 1'($urandom);
      logic [8:0] a = wm ? 9'($urandom % 256) : 9'($urandom % 512);
      logic [15:0] d = 16'($urandom);
      if (r < 38)      do_read(wm, a, $urandom % 3, 0);
      else if (r < 62) do_write(wm, a, d, "R5 R7 random write");
      else if (r < 72) do_erase(wm, a);
      else if (r < 82) do_ext(wm, 2'b11, 16'h0);
      else if (r < 86) do_ext(wm, 2'b00, 16'h0);
      else if (r < 88) do_ext(wm, 2'b10, 16'h0);
      else if (r < 90) do_ext(wm, 2'b01, d);
      else             do_read(wm, a, 0, 1);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule